// File: doc/BRIEF.md
# Shared Byte FIFO with Count Compare and Pattern Match

This block is a byte-wide first-in first-out store that sits between two processor ports. One side pushes bytes, the other pops them. A status section watches every transfer. It reports overflow and underflow errors. It keeps an occupancy count that software can freeze for a consistent read. It raises a flag when the occupancy reaches a programmed level. It also compares the most recently transferred byte against a reference value, under a mask.

The last byte moved in or out is held in a data buffer and driven on `pop_data`. The pattern match looks at this buffer. Each status event sets a sticky pending bit, and each pending bit has its own clear strobe. Every result is registered and appears on the first rising clock edge after the strobe that caused it.

Top module: `xfer_fifo_status`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs are in their reset state: `empty`=1, `full`=0, `byte_count`=0, `pop_data`=0, `count_frozen`=0, and every error and pending output is 0.
- R2: The FIFO holds up to DEPTH (128) bytes and pops them in the order they were pushed. After an accepted pop, `pop_data` shows the popped byte. After an accepted push alone, `pop_data` shows the pushed byte.
- R3: A push into a full FIFO is dropped, and the stored contents and count stay as they were. It sets `overflow` and `err_pend`.
- R4: A pop from an empty FIFO leaves `pop_data` unchanged. It sets `underflow` and `err_pend`.
- R5: A push and a pop in the same cycle, on a FIFO that is neither empty nor full, leave the occupancy unchanged. `pop_data` then shows the popped byte.
- R6: `byte_count` shows the live occupancy. A `freeze_set` pulse holds `byte_count` at the occupancy reached at that edge and raises `count_frozen`. A `count_rd` pulse releases the hold, so the live occupancy shows again from the next cycle.
- R7: `cmp_pend` sets when, after an accepted transfer, the occupancy equals the stored 7-bit compare value.
- R8: `cmp_pend` also sets on the edge of a `cmp_wr` strobe if the current occupancy equals the written `cmp_val`.
- R9: After each accepted transfer, the new data buffer is compared with `match_val`. Mask bits set to 1 in `match_mask` are don't-cares. A hit sets `match_flag` and `match_pend`. A miss clears `match_flag` only.
- R10: `full` and `empty` give the occupancy level. When a transfer leaves the FIFO at DEPTH, `full_pend` sets. When a transfer leaves it at 0, `empty_pend` sets.
- R11: `clear` empties the FIFO in one cycle (`empty`=1, `full`=0, count 0). A push or pop strobed in that same cycle is ignored.
- R12: Pending and error bits are sticky. `clr_err` clears `overflow`, `underflow` and `err_pend`. `clr_cmp`, `clr_match`, `clr_full` and `clr_empty` each clear their own bit. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Write strobe |
| push_data | input | DW | Byte to write |
| pop | input | 1 | Read strobe |
| pop_data | output | DW | Data buffer: last byte transferred |
| clear | input | 1 | Empty the FIFO |
| cmp_wr | input | 1 | Load compare value |
| cmp_val | input | AW | Compare value (7 bits) |
| match_val | input | DW | Pattern reference |
| match_mask | input | DW | Pattern don't-care mask (1 = ignore bit) |
| freeze_set | input | 1 | Freeze the byte count |
| count_rd | input | 1 | Byte count read; releases freeze |
| byte_count | output | CW | Occupancy, live or frozen |
| count_frozen | output | 1 | Freeze active |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| overflow | output | 1 | Push into full seen |
| underflow | output | 1 | Pop from empty seen |
| err_pend | output | 1 | Error pending |
| cmp_pend | output | 1 | Count compare pending |
| match_flag | output | 1 | Last transfer matched pattern |
| match_pend | output | 1 | Pattern match pending |
| full_pend | output | 1 | Full pending |
| empty_pend | output | 1 | Empty pending |
| clr_err | input | 1 | Clear error bits |
| clr_cmp | input | 1 | Clear compare pending |
| clr_match | input | 1 | Clear match pending |
| clr_full | input | 1 | Clear full pending |
| clr_empty | input | 1 | Clear empty pending |

## Verification
Every output of this block comes from a register, so the effect of a strobe is due at the first rising edge after the strobe was held. The bench drives each strobe for exactly one cycle. It then samples all outputs one nanosecond after that edge, before it changes anything else, and compares them with a transfer-level model updated at the same point. The freeze hold, the set-over-clear priority and the ignored strobes during `clear` are all checked in the cycle right after the stimulus. A full 256-value data sweep runs under two mask settings.

// File: rtl/xfer_fifo_status.sv
module xfer_fifo_status #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  input  logic          clear,
  input  logic          cmp_wr,
  input  logic [AW-1:0] cmp_val,
  input  logic [DW-1:0] match_val,
  input  logic [DW-1:0] match_mask,
  input  logic          freeze_set,
  input  logic          count_rd,
  output logic [CW-1:0] byte_count,
  output logic          count_frozen,
  output logic          full,
  output logic          empty,
  output logic          overflow,
  output logic          underflow,
  output logic          err_pend,
  output logic          cmp_pend,
  output logic          match_flag,
  output logic          match_pend,
  output logic          full_pend,
  output logic          empty_pend,
  input  logic          clr_err,
  input  logic          clr_cmp,
  input  logic          clr_match,
  input  logic          clr_full,
  input  logic          clr_empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, cmp_q;
  logic [CW-1:0] cnt, cnt_nxt, snap;
  logic [DW-1:0] dbuf, buf_nxt;
  logic          frozen;

  assign full  = cnt == CW'(DEPTH);
  assign empty = cnt == '0;

  wire push_ok = push && !clear && !full;
  wire pop_ok  = pop  && !clear && !empty;
  wire moved   = push_ok || pop_ok;
  wire ov_ev   = push && !clear && full;
  wire uf_ev   = pop  && !clear && empty;

  always_comb begin
    cnt_nxt = cnt;
    if (clear)                  cnt_nxt = '0;
    else if (push_ok && !pop_ok) cnt_nxt = cnt + CW'(1);
    else if (pop_ok && !push_ok) cnt_nxt = cnt - CW'(1);
  end

  // R5: a popped byte takes the data buffer ahead of a pushed one
  assign buf_nxt = pop_ok ? mem[rp] : (push_ok ? push_data : dbuf);

  // R9: masked compare on the buffer value the transfer leaves behind
  wire hit = ((buf_nxt ^ match_val) & ~match_mask) == '0;

  assign pop_data     = dbuf;
  assign byte_count   = frozen ? snap : cnt;
  assign count_frozen = frozen;

  always_ff @(posedge clk)
    if (push_ok) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp         <= '0;
      rp         <= '0;
      cnt        <= '0;
      snap       <= '0;
      dbuf       <= '0;
      frozen     <= 1'b0;
      cmp_q      <= '0;
      overflow   <= 1'b0;
      underflow  <= 1'b0;
      err_pend   <= 1'b0;
      cmp_pend   <= 1'b0;
      match_flag <= 1'b0;
      match_pend <= 1'b0;
      full_pend  <= 1'b0;
      empty_pend <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      dbuf <= buf_nxt;
      if (clear) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push_ok) wp <= wp + AW'(1);
        if (pop_ok)  rp <= rp + AW'(1);
      end
      // R6: snapshot follows the count until the hold is taken
      if (!frozen) snap <= cnt_nxt;
      frozen <= count_rd ? 1'b0 : (frozen | freeze_set);
      if (cmp_wr) cmp_q <= cmp_val;
      // R12: set terms win over clear strobes
      overflow   <= (overflow  & ~clr_err) | ov_ev;
      underflow  <= (underflow & ~clr_err) | uf_ev;
      err_pend   <= (err_pend  & ~clr_err) | ov_ev | uf_ev;
      cmp_pend   <= (cmp_pend & ~clr_cmp)
                  | (moved && cnt_nxt == CW'(cmp_q))
                  | (cmp_wr && cnt == CW'(cmp_val));
      if (moved) match_flag <= hit;
      match_pend <= (match_pend & ~clr_match) | (moved && hit);
      full_pend  <= (full_pend  & ~clr_full)  | (moved && cnt_nxt == CW'(DEPTH));
      empty_pend <= (empty_pend & ~clr_empty) | (moved && cnt_nxt == '0);
    end
  end

endmodule

// File: rtl/xfer_fifo_status_chk.sv
module xfer_fifo_status_chk #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic          clear,
  input logic          count_rd,
  input logic          clr_cmp,
  input logic          full,
  input logic          empty,
  input logic          overflow,
  input logic          underflow,
  input logic          err_pend,
  input logic          cmp_pend,
  input logic          count_frozen,
  input logic [DW-1:0] pop_data,
  input logic [CW-1:0] byte_count
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clear && full) |=> (full && overflow && err_pend));

  assert_underflow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clear && empty) |=> ($stable(pop_data) && underflow && err_pend));

  assert_pair_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !clear && !full && !empty && !count_frozen) |=> $stable(byte_count));

  assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_frozen && !count_rd) |=> $stable(byte_count));

  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (empty && !full));

  assert_cmp_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_pend && !clr_cmp) |=> cmp_pend);

endmodule

bind xfer_fifo_status xfer_fifo_status_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/sim_xfer_fifo_status.sv
module sim_xfer_fifo_status;
  localparam int DEPTH = 128;

  logic clk = 0, rst_n = 0;
  logic push = 0, pop = 0, clear = 0, cmp_wr = 0, freeze_set = 0, count_rd = 0;
  logic clr_err = 0, clr_cmp = 0, clr_match = 0, clr_full = 0, clr_empty = 0;
  logic [7:0] push_data = 0, match_val = 0, match_mask = 0;
  logic [6:0] cmp_val = 0;
  logic [7:0] pop_data, byte_count;
  logic count_frozen, full, empty, overflow, underflow, err_pend, cmp_pend;
  logic match_flag, match_pend, full_pend, empty_pend;

  xfer_fifo_status u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int q [0:4095];
  int hd = 0, tl = 0;
  int e_buf = 0, cmpv = 0, snap = 0;
  bit e_ov, e_uf, e_err, e_cmp, e_mf, e_mp, e_fp, e_ep, frz;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_all();
    chk("R6 byte_count", byte_count, frz ? snap : tl - hd);
    chk("R6 count_frozen", count_frozen, frz);
    chk("R10 full", full, (tl - hd) == DEPTH);
    chk("R10 empty", empty, tl == hd);
    chk("R3 overflow", overflow, e_ov);
    chk("R4 underflow", underflow, e_uf);
    chk("R3 err_pend", err_pend, e_err);
    chk("R7 cmp_pend", cmp_pend, e_cmp);
    chk("R9 match_flag", match_flag, e_mf);
    chk("R9 match_pend", match_pend, e_mp);
    chk("R10 full_pend", full_pend, e_fp);
    chk("R10 empty_pend", empty_pend, e_ep);
    chk("R2 pop_data", pop_data, e_buf);
  endtask

  task automatic xfer(bit ps, bit pp, int d);
    int c;
    bit pok, wok;
    c = tl - hd;
    pok = pp && c > 0;
    wok = ps && c < DEPTH;
    push = ps; pop = pp; push_data = 8'(d);
    step();
    push = 0; pop = 0;
    if (ps && !wok) begin e_ov = 1; e_err = 1; end
    if (pp && !pok) begin e_uf = 1; e_err = 1; end
    if (pok) begin e_buf = q[hd]; hd++; end
    else if (wok) e_buf = d;
    if (wok) begin q[tl] = d; tl++; end
    if (pok || wok) begin
      e_mf = ((8'(e_buf) ^ match_val) & ~match_mask) == 8'h00;
      if (e_mf) e_mp = 1;
      if (tl - hd == cmpv) e_cmp = 1;
      if (tl - hd == DEPTH) e_fp = 1;
      if (tl == hd) e_ep = 1;
    end
    check_all();
  endtask

  task automatic cmp_write(int v, bit with_clr);
    cmp_wr = 1; cmp_val = 7'(v); clr_cmp = with_clr;
    step();
    cmp_wr = 0; clr_cmp = 0;
    if (with_clr) e_cmp = 0;
    if (tl - hd == v) e_cmp = 1;
    cmpv = v;
    check_all();
  endtask

  task automatic clr(bit e, bit c, bit m, bit f, bit y);
    clr_err = e; clr_cmp = c; clr_match = m; clr_full = f; clr_empty = y;
    step();
    clr_err = 0; clr_cmp = 0; clr_match = 0; clr_full = 0; clr_empty = 0;
    if (e) begin e_ov = 0; e_uf = 0; e_err = 0; end
    if (c) e_cmp = 0;
    if (m) e_mp = 0;
    if (f) e_fp = 0;
    if (y) e_ep = 0;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 empty in reset", empty, 1);
    chk("R1 count in reset", byte_count, 0);
    rst_n = 1;
    step();
    chk("R1 full", full, 0);
    chk("R1 pop_data", pop_data, 0);
    chk("R1 err_pend", err_pend, 0);
    check_all();

    match_val = 8'h50; match_mask = 8'h0F;
    // R8: write a compare value equal to the current count (0)
    cmp_write(0, 0);
    chk("R8 cmp_pend on write", cmp_pend, 1);
    clr(0, 1, 0, 0, 0);
    // R12: set beats clear in the same cycle
    cmp_write(0, 1);
    chk("R12 set wins", cmp_pend, 1);
    clr(0, 1, 0, 0, 0);
    cmp_write(5, 0);

    // R2 R7 R9 R10: fill to depth
    for (int i = 0; i < DEPTH; i++) xfer(1, 0, (i * 37 + 11) & 255);
    chk("R10 full at depth", full, 1);
    // R3: push into full is dropped
    xfer(1, 0, 8'hEE);
    chk("R3 count held", byte_count, DEPTH);
    clr(1, 0, 0, 0, 0);

    // R6: freeze, pop, then release with a count read
    freeze_set = 1; step(); freeze_set = 0;
    frz = 1; snap = tl - hd;
    check_all();
    for (int i = 0; i < 3; i++) xfer(0, 1, 0);
    chk("R6 frozen count", byte_count, DEPTH);
    count_rd = 1; step(); count_rd = 0;
    frz = 0;
    check_all();
    chk("R6 live after read", byte_count, DEPTH - 3);

    // R5: paired transfers keep the count
    for (int k = 0; k < 8; k++) xfer(1, 1, 8'hC0 + k);
    chk("R5 count kept", byte_count, DEPTH - 3);

    // R2: drain, checking order; R10 empty pending at the end
    while (tl != hd) xfer(0, 1, 0);
    chk("R10 empty_pend", empty_pend, 1);
    // R4: pop from empty
    xfer(0, 1, 0);
    chk("R4 underflow", underflow, 1);
    clr(1, 1, 1, 1, 1);

    // R11: clear with a push in the same cycle
    for (int i = 0; i < 3; i++) xfer(1, 0, 8'h11 + i);
    clear = 1; push = 1; push_data = 8'h22;
    step();
    clear = 0; push = 0;
    hd = tl;
    check_all();
    chk("R11 count zero", byte_count, 0);
    chk("R11 empty", empty, 1);
    clr(0, 1, 1, 1, 1);

    // R9: full data sweep under two masks
    for (int p = 0; p < 2; p++) begin
      match_val  = p ? 8'h3C : 8'h50;
      match_mask = p ? 8'hC3 : 8'h0F;
      for (int d = 0; d < 256; d++) begin
        xfer(1, 0, d);
        xfer(0, 1, 0);
      end
      clr(0, 0, 1, 0, 0);
      chk("R12 match_pend cleared", match_pend, 0);
    end
    clr(1, 1, 1, 1, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule